// File: doc/BRIEF.md
# Frequency-Tracking Quadrature Sine Synthesizer

This block follows an external sine wave whose frequency lies anywhere between 5 kHz and 50 kHz. The block only sees the wave after an analog comparator has turned it into a logic-level square wave. The block counts system-clock ticks between successive rising edges of that square wave, which is a reciprocal frequency measurement. It then divides a full accumulator turn by that count to obtain a phase step. It hands that step to two phase accumulators in the same cycle.

The two accumulators start a quarter turn apart and always advance by the same amount, so their phases stay locked 90 degrees apart. The top bits of each accumulator address a full-cycle sine table. The table yields a registered, signed 12-bit sample whose amplitude is fixed and does not change with frequency. The sign of each phase also gives a square wave. Inverting the two squares gives the 180 and 270 degree versions. The DAC, its reconstruction filter and the input comparator lie outside the block.

Top module: `quadTrackDds`

## Requirements
- R1: A synchronous active-high `rst` does the following. It clears `outValid`, zeroes the phase step, and returns the in-phase accumulator to 0 and the quadrature accumulator to code 0xC0 in its top 8 bits. It also zeroes all four sample and square outputs. On the first edge after reset, `sinI` reads 0 and `sinQ` reads -2047.
- R2: `cmpIn` passes through a two-stage synchronizer. The period is the number of clock edges between two successive detected rising edges. The phase step is floor(2^ACC_W / period).
- R3: The quadrature accumulator always equals the in-phase accumulator plus 0xC0 placed in its top 8 bits, modulo 2^ACC_W. This means the quadrature output lags by a quarter cycle.
- R4: A period below MIN_PERIOD or above MAX_PERIOD is discarded, and the previous phase step is kept. Both limits themselves are accepted. A gap longer than MAX_PERIOD saturates the tick counter and is rejected.
- R5: Suppose a rising edge of `cmpIn` is first sampled at clock edge k. Then the new step is committed at edge k+ACC_W+4. Both accumulators first advance by it together at edge k+ACC_W+5. A rising edge detected while a division is still running is not measured.
- R6: `outValid` is low until the first accepted measurement is committed. It needs two rising edges: the first only arms the counter. It then stays high until reset.
- R7: Each sample is registered one edge after the accumulator value that addressed it. The address is the top 8 bits of the accumulator, and the sample is a two's-complement value within 4 counts of 2047·sin(2π·index/256). Indices 0, 64, 128 and 192 give exactly 0, 2047, 0 and -2047.
- R8: `sqI` and `sqQ` are registered in the same stage as the samples. Each is 1 exactly when the MSB of its accumulator was 0, that is, during the positive half of its sine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | 1 | Comparator output for the input sine, asynchronous |
| sinI | output | 12 | In-phase sine sample, signed |
| sinQ | output | 12 | Quadrature sine sample (lags 90 degrees), signed |
| sqI | output | 1 | In-phase square wave |
| sqQ | output | 1 | Quadrature square wave |
| outValid | output | 1 | A tracked frequency is in use |

## Verification
The bench drives edge gaps of exactly MIN_PERIOD and MAX_PERIOD and expects both to be accepted. It also drives one gap just above the maximum, a pulse far below the minimum, and a gap long enough to saturate the tick counter. A design with an off-by-one range compare or a wrapping counter would then retune to a wrong step, and every later sample would drift from the model. The model tracks the exact edge on which the new step lands. A pipeline that is one stage too long or short, or that updates the two accumulators on different edges, therefore shows up as sample and square mismatches and a broken quarter-cycle offset. A reset in the middle of the run checks that the preloads and the arming edge are restored. Without that, the quadrature output would start at the wrong phase or `outValid` would come back too early.

// File: rtl/quadDdsPkg.sv
package quadDdsPkg;
  localparam int SAMPLE_W  = 12;
  localparam int IDX_W     = 8;
  localparam int AMPLITUDE = 2047;
  localparam int CHANNELS  = 2;
  // start code of each channel in the accumulator's top bits: a quarter turn apart
  localparam logic [IDX_W-1:0] PRELOAD_CODE [CHANNELS] = '{8'h00, 8'hC0};

  typedef struct packed {
    logic loadDiv;
    logic stepDiv;
    logic commitInc;
  } ddsStrobeT;
endpackage

// File: rtl/qdSineRom.sv
module qdSineRom #(
  parameter int IDX_W     = 8,
  parameter int SAMPLE_W  = 12,
  parameter int AMPLITUDE = 2047
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    idx,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int ENTRIES    = 1 << IDX_W;
  localparam int HALF       = ENTRIES / 2;
  localparam int TABLE_BITS = ENTRIES * SAMPLE_W;

  // rational sine approximation over each half turn, integer only
  function automatic logic [TABLE_BITS-1:0] buildTable();
    logic [TABLE_BITS-1:0] tbl;
    int pos, prod, num, den, val;
    tbl = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      pos  = i % HALF;
      prod = pos * (HALF - pos);
      num  = 16 * prod * AMPLITUDE;
      den  = 5 * HALF * HALF - 4 * prod;
      val  = (num + den / 2) / den;
      if (i >= HALF) val = -val;
      tbl[i*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(val);
    end
    return tbl;
  endfunction

  localparam logic [TABLE_BITS-1:0] SINE_TABLE = buildTable();

  always_ff @(posedge clk) begin
    if (rst) sample <= '0;
    else     sample <= SINE_TABLE[idx*SAMPLE_W +: SAMPLE_W];
  end
endmodule

// File: rtl/qdControl.sv
module qdControl
  import quadDdsPkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int MIN_PERIOD = 900,
  parameter int MAX_PERIOD = 11000,
  parameter int CNT_W      = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmpIn,
  output ddsStrobeT        stb,
  output logic [CNT_W-1:0] periodOut,
  output logic             measValid
);
  localparam int STEP_W = $clog2(ACC_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DIVIDE, ST_COMMIT} ctlStateT;

  logic [2:0]        syncQ;
  logic              riseSeen;
  logic [CNT_W-1:0]  tickCnt;
  logic              armed;
  logic              inRange;
  ctlStateT          state;
  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[1:0], cmpIn};
  end

  assign riseSeen = syncQ[1] & ~syncQ[2];

  // ticks since last rising edge, held at the upper limit
  always_ff @(posedge clk) begin
    if (rst || riseSeen)                       tickCnt <= '0;
    else if (tickCnt != CNT_W'(MAX_PERIOD))    tickCnt <= tickCnt + CNT_W'(1);
  end

  assign periodOut = tickCnt + CNT_W'(1);
  assign inRange   = (periodOut >= CNT_W'(MIN_PERIOD)) && (periodOut <= CNT_W'(MAX_PERIOD));

  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (riseSeen) armed <= 1'b1;
  end

  assign stb.loadDiv   = riseSeen && armed && inRange && (state == ST_IDLE);
  assign stb.stepDiv   = (state == ST_DIVIDE);
  assign stb.commitInc = (state == ST_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (stb.loadDiv) begin
          state   <= ST_DIVIDE;
          stepCnt <= STEP_W'(ACC_W);
        end
        ST_DIVIDE: begin
          if (stepCnt == '0) state <= ST_COMMIT;
          else               stepCnt <= stepCnt - STEP_W'(1);
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                measValid <= 1'b0;
    else if (stb.commitInc) measValid <= 1'b1;
  end
endmodule

// File: rtl/qdDatapath.sv
module qdDatapath
  import quadDdsPkg::*;
#(
  parameter int ACC_W = 32,
  parameter int CNT_W = 14
) (
  input  logic                               clk,
  input  logic                               rst,
  input  ddsStrobeT                          stb,
  input  logic [CNT_W-1:0]                   periodIn,
  output logic [ACC_W-1:0]                   incr,
  output logic [CHANNELS-1:0][ACC_W-1:0]     phase,
  output logic [CHANNELS-1:0][SAMPLE_W-1:0]  sinOut,
  output logic [CHANNELS-1:0]                sqOut
);
  // restoring divider for 2^ACC_W / period, one quotient bit per step
  logic [CNT_W-1:0] divisor;
  logic [CNT_W-1:0] remain;
  logic [ACC_W-1:0] quot;
  logic             leadBit;
  logic [CNT_W:0]   trial;
  logic             fits;
  logic [CNT_W-1:0] diff;

  assign trial = {remain, leadBit};
  assign fits  = trial >= {1'b0, divisor};
  assign diff  = trial[CNT_W-1:0] - divisor;

  always_ff @(posedge clk) begin
    if (rst) begin
      divisor <= '0;
      remain  <= '0;
      quot    <= '0;
      leadBit <= 1'b0;
    end else if (stb.loadDiv) begin
      divisor <= periodIn;
      remain  <= '0;
      quot    <= '0;
      leadBit <= 1'b1;
    end else if (stb.stepDiv) begin
      remain  <= fits ? diff : trial[CNT_W-1:0];
      quot    <= {quot[ACC_W-2:0], fits};
      leadBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                incr <= '0;
    else if (stb.commitInc) incr <= quot;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : gChan
    localparam logic [ACC_W-1:0] PRELOAD = {PRELOAD_CODE[c], {(ACC_W-IDX_W){1'b0}}};

    always_ff @(posedge clk) begin
      if (rst) phase[c] <= PRELOAD;
      else     phase[c] <= phase[c] + incr;
    end

    always_ff @(posedge clk) begin
      if (rst) sqOut[c] <= 1'b0;
      else     sqOut[c] <= ~phase[c][ACC_W-1];
    end

    qdSineRom #(
      .IDX_W    (IDX_W),
      .SAMPLE_W (SAMPLE_W),
      .AMPLITUDE(AMPLITUDE)
    ) rom_i (
      .clk   (clk),
      .rst   (rst),
      .idx   (phase[c][ACC_W-1 -: IDX_W]),
      .sample(sinOut[c])
    );
  end
endmodule

// File: rtl/quadTrackDds.sv
module quadTrackDds
  import quadDdsPkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int MIN_PERIOD = 900,
  parameter int MAX_PERIOD = 11000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmpIn,
  output logic signed [SAMPLE_W-1:0] sinI,
  output logic signed [SAMPLE_W-1:0] sinQ,
  output logic                       sqI,
  output logic                       sqQ,
  output logic                       outValid
);
  localparam int CNT_W = $clog2(MAX_PERIOD + 2);

  ddsStrobeT                         ctrlStb;
  logic [CNT_W-1:0]                  periodVal;
  logic [ACC_W-1:0]                  incrVal;
  logic [CHANNELS-1:0][ACC_W-1:0]    phaseVec;
  logic [CHANNELS-1:0][SAMPLE_W-1:0] sinVec;
  logic [CHANNELS-1:0]               sqVec;

  qdControl #(
    .ACC_W     (ACC_W),
    .MIN_PERIOD(MIN_PERIOD),
    .MAX_PERIOD(MAX_PERIOD),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .cmpIn    (cmpIn),
    .stb      (ctrlStb),
    .periodOut(periodVal),
    .measValid(outValid)
  );

  qdDatapath #(
    .ACC_W(ACC_W),
    .CNT_W(CNT_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .stb     (ctrlStb),
    .periodIn(periodVal),
    .incr    (incrVal),
    .phase   (phaseVec),
    .sinOut  (sinVec),
    .sqOut   (sqVec)
  );

  assign sinI = sinVec[0];
  assign sinQ = sinVec[1];
  assign sqI  = sqVec[0];
  assign sqQ  = sqVec[1];
endmodule

// File: rtl/quadTrackDdsChk.sv
module quadTrackDdsChk
  import quadDdsPkg::*;
#(
  parameter int ACC_W      = 32,
  parameter int MIN_PERIOD = 900,
  parameter int MAX_PERIOD = 11000
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] phaseI,
  input logic [ACC_W-1:0] phaseQ,
  input logic [ACC_W-1:0] incr,
  input logic             commitInc,
  input logic             outValid,
  input logic             sqI,
  input logic             sqQ
);
  localparam logic [ACC_W-1:0] OFFSET = {PRELOAD_CODE[1], {(ACC_W-IDX_W){1'b0}}};
  localparam longint FULL_TURN = longint'(1) << ACC_W;
  localparam logic [ACC_W-1:0] INC_LO = ACC_W'(FULL_TURN / MAX_PERIOD);
  localparam logic [ACC_W-1:0] INC_HI = ACC_W'(FULL_TURN / MIN_PERIOD);

  AST_QUAD_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (phaseQ - phaseI) == OFFSET); // R3
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid |=> outValid); // R6
  AST_INC_ZERO_BEFORE_VALID: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (incr == '0)); // R6
  AST_INC_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commitInc |=> $stable(incr)); // R5
  AST_INC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    commitInc |=> (incr >= INC_LO && incr <= INC_HI)); // R4
  AST_SQ_QUADRATURE: assert property (@(posedge clk) disable iff (rst)
    $rose(sqI) |-> !sqQ); // R8
endmodule

bind quadTrackDds quadTrackDdsChk #(
  .ACC_W     (ACC_W),
  .MIN_PERIOD(MIN_PERIOD),
  .MAX_PERIOD(MAX_PERIOD)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .phaseI   (phaseVec[0]),
  .phaseQ   (phaseVec[1]),
  .incr     (incrVal),
  .commitInc(ctrlStb.commitInc),
  .outValid (outValid),
  .sqI      (sqI),
  .sqQ      (sqQ)
);

// File: tb/quadTrackDds_tb.sv
module quadTrackDds_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W  = 16;
  localparam int MIN_P  = 24;
  localparam int MAX_P  = 600;
  localparam longint MASK = (longint'(1) << ACC_W) - 1;
  localparam longint Q_PRE = longint'(8'hC0) << (ACC_W - 8);
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst;
  logic cmpIn;
  logic signed [11:0] sinI, sinQ;
  logic sqI, sqQ, outValid;

  int tests = 0;
  int fails = 0;
  string stage = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  quadTrackDds #(.ACC_W(ACC_W), .MIN_PERIOD(MIN_P), .MAX_PERIOD(MAX_P)) dut_i (
    .clk(clk), .rst(rst), .cmpIn(cmpIn), .sinI(sinI), .sinQ(sinQ),
    .sqI(sqI), .sqQ(sqQ), .outValid(outValid)
  );

  // reference model state
  longint cyc = 0;
  longint mAccI, mAccQ, mInc;
  bit     mValid;
  real    eSinI, eSinQ;
  bit     eSqI, eSqQ;
  longint applyQ[$];
  longint incQ[$];
  bit     haveLast;
  longint lastN;
  longint busyEnd;
  bit     checkOn = 0;

  function automatic real refSin(longint acc);
    longint idx;
    idx = (acc >> (ACC_W - 8)) & 255;
    return 2047.0 * $sin(2.0 * PI * real'(idx) / 256.0);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mAccI = 0; mAccQ = Q_PRE; mInc = 0; mValid = 0;
      eSinI = 0.0; eSinQ = 0.0; eSqI = 0; eSqQ = 0;
      applyQ.delete(); incQ.delete();
      haveLast = 0; busyEnd = -1;
    end else begin
      eSinI = refSin(mAccI);
      eSinQ = refSin(mAccQ);
      eSqI  = ((mAccI >> (ACC_W - 1)) & 1) == 0;
      eSqQ  = ((mAccQ >> (ACC_W - 1)) & 1) == 0;
      mAccI = (mAccI + mInc) & MASK;
      mAccQ = (mAccQ + mInc) & MASK;
      if (applyQ.size() > 0 && applyQ[0] == cyc) begin
        void'(applyQ.pop_front());
        mInc   = incQ.pop_front();
        mValid = 1;
      end
    end
  end

  // called at the negedge where cmpIn is raised; cyc = edges seen so far
  task automatic modelRise();
    longint n, per;
    n = cyc;
    if (haveLast) begin
      per = n - lastN;
      if (per >= MIN_P && per <= MAX_P && (n + 3) > busyEnd) begin
        applyQ.push_back(n + 5 + ACC_W);
        incQ.push_back((longint'(1) << ACC_W) / per);
        busyEnd = n + 5 + ACC_W;
      end
    end
    lastN = n;
    haveLast = 1;
  endtask

  task automatic checkBit(string tag, string name, bit act, bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at cycle %0d", tag, name, act, exp, cyc);
    end
  endtask

  task automatic checkNear(string tag, string name, int act, real exp);
    real d;
    tests++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > 4.0) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0.1f at cycle %0d", tag, name, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (checkOn) begin
      checkNear({stage, "/R7"}, "sinI", int'(sinI), eSinI);
      checkNear({stage, "/R3"}, "sinQ", int'(sinQ), eSinQ);
      checkBit({stage, "/R8"}, "sqI", sqI, eSqI);
      checkBit({stage, "/R8"}, "sqQ", sqQ, eSqQ);
      checkBit({stage, "/R6"}, "outValid", outValid, mValid);
    end
  end

  task automatic gapRise(int gap);
    cmpIn = 1'b1;
    modelRise();
    repeat (gap / 2) @(negedge clk);
    cmpIn = 1'b0;
    repeat (gap - gap / 2) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    cmpIn = 1'b0;
    repeat (2) @(negedge clk);
    checkOn = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: first samples after reset show the preloads
    checkNear("R1", "sinI after reset", int'(sinI), 0.0);
    checkNear("R1", "sinQ after reset", int'(sinQ), -2047.0);
    checkBit("R1", "outValid after reset", outValid, 1'b0);
    repeat (40) @(negedge clk);
    stage = "R6";
    gapRise(300);
    checkBit("R6", "valid after one edge only", outValid, 1'b0);
    stage = "R2";
    repeat (5) gapRise(100);
    stage = "R5";
    repeat (4) gapRise(64);
    stage = "R4";
    gapRise(10);
    checkBit("R4", "valid kept after short gap", outValid, 1'b1);
    gapRise(200);
    gapRise(700);
    repeat (3) gapRise(500);
    gapRise(MIN_P);
    gapRise(MAX_P);
    gapRise(MAX_P + 1);
    gapRise(150);
    stage = "R1";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkNear("R1", "sinQ after second reset", int'(sinQ), -2047.0);
    checkBit("R1", "valid cleared by reset", outValid, 1'b0);
    repeat (20) @(negedge clk);
    stage = "R6";
    gapRise(150);
    checkBit("R6", "rearm needs two edges", outValid, 1'b0);
    stage = "R2";
    repeat (3) gapRise(150);
    repeat (200) @(negedge clk);
    checkOn = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule